// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block reads a 5x5 switch matrix through five row drive outputs and five active-low column inputs that are pulled high. While nothing happens, all rows are driven low. A press therefore pulls its column low no matter which row the key sits on. A press or release seen on the columns wakes the scanner. From then on it walks the rows one at a time and records the state of every switch. It keeps scanning until a host sends a stop strobe.

After the first complete pass over all rows, an interrupt line rises and stays high until the scan is stopped. If a key changes after that pass but before the stop, the first stop is treated as stale. It only clears the pending change, and a second stop is needed to halt the scan. The switch-state vector is a level output that a parallel-in shift-out stage can sample at any time. It carries no handshake and applies no back-pressure. Row timing is set by counting ticks of an external bit-time enable. Contact bounce is not filtered.

Top module: `keymx_scanner`

## Requirements
- R1: After reset, `row_o` is all zeros, `irq_o` is low and `keys_o` is all zeros. While idle, every row output stays low.
- R2: While idle, a change of the synchronised column inputs starts scanning within five clock cycles. The change can be a press or a release. While scanning, the row being read is driven low and every other row is driven high.
- R3: Once started, scanning repeats pass after pass for as long as no stop is accepted.
- R4: `irq_o` rises at the end of the first full pass after a start and stays high until an accepted stop. It is never high while idle.
- R5: A stop strobe during scanning with no pending change makes `row_o` all zeros and `irq_o` low on the next clock edge.
- R6: While scanning, exactly one row is low at a time, in the order row 0 to row 4, and each row is held for `ROW_TICKS` ticks. A row changes only on a tick or on a stop.
- R7: Bit `5*r+c` of `keys_o` (rows r and columns c both counted from 0) is 1 exactly when the switch at row r, column c was closed when row r was last read.
- R8: Suppose a row read after the first full pass differs from the stored state of that row. The next stop strobe then only clears this pending change, and scanning continues with `irq_o` high. A later stop strobe, with no new change in between, ends the scan.
- R9: A stop strobe while idle has no effect: the rows stay low and `irq_o` stays low.
- R10: When the block returns to idle with keys still held, it does not restart by itself. It restarts only when a column actually changes after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Bit-time enable, one clock wide |
| col_ni | input | COLS | Column return lines, active low |
| stop_i | input | 1 | Stop strobe from the host, one clock wide |
| row_o | output | ROWS | Row drive lines |
| irq_o | output | 1 | Interrupt, high after the first full pass |
| keys_o | output | ROWS*COLS | Switch-state vector, 1 = closed |

## Verification
The scanner is driven by a matrix model with ideal diodes, tried with several key patterns. A single key in the middle of the matrix checks bit placement. Four keys spread over the corners and the inner area show whether the rows and columns are swapped. A release from idle shows that releases start a scan as well as presses. A key held across a stop separates true change detection from the level shift that happens when the rows return low. A release between the first pass and the stop separates the stale-stop rule from a plain stop.

// File: rtl/kms_pkg.sv
package kms_pkg;
  typedef enum logic {KS_IDLE = 1'b0, KS_SCAN = 1'b1} kms_state_e;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/kms_sync.sv
module kms_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/kms_change_detect.sv
module kms_change_detect
  import kms_pkg::*;
#(
  parameter int unsigned COLS = 5,
  parameter int unsigned ARM  = 3,
  localparam int unsigned AW  = bits_for(ARM + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scanning_i,
  input  logic [COLS-1:0] col_s_i,
  output logic            start_o
);
  logic [COLS-1:0] prev_q;
  logic [AW-1:0]   arm_q;

  // After reset or a return to idle, the columns settle before comparison.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      arm_q  <= AW'(ARM);
    end else begin
      prev_q <= col_s_i;
      if (scanning_i)       arm_q <= AW'(ARM);
      else if (arm_q != '0) arm_q <= arm_q - 1'b1;
    end
  end

  assign start_o = !scanning_i && (arm_q == '0) && (col_s_i != prev_q);
endmodule

// File: rtl/kms_capture.sv
module kms_capture
  import kms_pkg::*;
#(
  parameter int unsigned ROWS = 5,
  parameter int unsigned COLS = 5,
  localparam int unsigned RW  = bits_for(ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic [RW-1:0]        row_i,
  input  logic [COLS-1:0]      col_s_i,
  output logic                 diff_o,
  output logic [ROWS*COLS-1:0] keys_o
);
  logic [ROWS-1:0] row_diff;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] st_q;
    logic            hit;
    assign hit = sample_i && (row_i == RW'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  st_q <= '0;
      else if (hit) st_q <= ~col_s_i;
    end

    assign row_diff[r]             = hit && (~col_s_i != st_q);
    assign keys_o[r*COLS +: COLS]  = st_q;
  end

  assign diff_o = |row_diff;
endmodule

// File: rtl/kms_sequencer.sv
module kms_sequencer
  import kms_pkg::*;
#(
  parameter int unsigned ROWS      = 5,
  parameter int unsigned ROW_TICKS = 39,
  localparam int unsigned RW       = bits_for(ROWS),
  localparam int unsigned TW       = bits_for(ROW_TICKS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            diff_i,
  output logic            scanning_o,
  output logic            again_o,
  output logic            irq_o,
  output logic            sample_o,
  output logic [RW-1:0]   row_idx_o,
  output logic [ROWS-1:0] row_o
);
  kms_state_e    state_q;
  logic [RW-1:0] row_q;
  logic [TW-1:0] tcnt_q;
  logic          irq_q, again_q;
  logic          scan, row_end, halt;

  assign scan    = (state_q == KS_SCAN);
  assign row_end = scan && tick_i && (tcnt_q == TW'(ROW_TICKS - 1));
  assign halt    = scan && stop_i && !again_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_IDLE;
      row_q   <= '0;
      tcnt_q  <= '0;
      irq_q   <= 1'b0;
      again_q <= 1'b0;
    end else if (!scan) begin
      if (start_i) begin
        state_q <= KS_SCAN;
        row_q   <= '0;
        tcnt_q  <= '0;
        again_q <= 1'b0;
      end
    end else if (halt) begin
      state_q <= KS_IDLE;
      row_q   <= '0;
      tcnt_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (stop_i)              again_q <= 1'b0;
      else if (diff_i && irq_q) again_q <= 1'b1;
      if (tick_i) begin
        if (row_end) begin
          tcnt_q <= '0;
          if (row_q == RW'(ROWS - 1)) begin
            row_q <= '0;
            irq_q <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

  assign scanning_o = scan;
  assign again_o    = again_q;
  assign irq_o      = irq_q;
  assign sample_o   = row_end;
  assign row_idx_o  = row_q;
  assign row_o      = scan ? ~(ROWS'(1) << row_q) : '0;
endmodule

// File: rtl/keymx_scanner.sv
module keymx_scanner
  import kms_pkg::*;
#(
  parameter int unsigned ROWS        = 5,
  parameter int unsigned COLS        = 5,
  parameter int unsigned ROW_TICKS   = 39,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RW         = bits_for(ROWS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [COLS-1:0]      col_ni,
  input  logic                 stop_i,
  output logic [ROWS-1:0]      row_o,
  output logic                 irq_o,
  output logic [ROWS*COLS-1:0] keys_o
);
  logic [COLS-1:0] col_s;
  logic            scanning, again_pend, start, diff, sample;
  logic [RW-1:0]   row_idx;

  kms_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(col_ni), .q_o(col_s));

  kms_change_detect #(.COLS(COLS), .ARM(SYNC_STAGES + 1)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .scanning_i(scanning),
    .col_s_i(col_s), .start_o(start));

  kms_sequencer #(.ROWS(ROWS), .ROW_TICKS(ROW_TICKS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start),
    .stop_i(stop_i), .diff_i(diff), .scanning_o(scanning),
    .again_o(again_pend), .irq_o(irq_o), .sample_o(sample),
    .row_idx_o(row_idx), .row_o(row_o));

  kms_capture #(.ROWS(ROWS), .COLS(COLS)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample), .row_i(row_idx),
    .col_s_i(col_s), .diff_o(diff), .keys_o(keys_o));
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int unsigned ROWS = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic            stop_i,
  input logic [ROWS-1:0] row_o,
  input logic            irq_o,
  input logic            scanning,
  input logic            again_pend
);
  AST_IDLE_ROWS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scanning |-> row_o == '0);  // R1
  AST_IRQ_ONLY_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> scanning);  // R4
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !stop_i |=> irq_o);  // R4
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanning && stop_i && !again_pend |=> (row_o == '0) && !irq_o);  // R5
  AST_ONE_ROW_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanning |-> $countones(row_o) == ROWS - 1);  // R6
  AST_ROW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanning && !tick_i && !stop_i |=> $stable(row_o));  // R6
  AST_STALE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scanning && stop_i && again_pend |=> row_o != '0);  // R8
  AST_IDLE_STOP_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scanning && stop_i |=> !irq_o);  // R9
endmodule

bind keymx_scanner kms_checker #(.ROWS(ROWS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .stop_i(stop_i),
  .row_o(row_o), .irq_o(irq_o), .scanning(scanning), .again_pend(again_pend));

// File: tb/sim_keymx_scanner.sv
module sim_keymx_scanner;
  localparam int unsigned NR = 5;
  localparam int unsigned NC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          stop = 1'b0;
  logic [NC-1:0] col_n;
  logic [NR-1:0] row;
  logic          irq;
  logic [24:0]   keys;
  logic [24:0]   pressed = '0;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  keymx_scanner #(.ROWS(NR), .COLS(NC), .ROW_TICKS(3), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .col_ni(col_n),
    .stop_i(stop), .row_o(row), .irq_o(irq), .keys_o(keys));

  // Ideal matrix: a column is low when a closed key sits on a low row.
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < NR; r++)
        if (pressed[r*NC+c] && !row[r]) col_n[c] = 1'b0;
    end
  end

  initial begin
    forever begin
      repeat (3) @(posedge clk);
      tick <= 1'b1;
      @(posedge clk);
      tick <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    check("R1 rows at reset", 32'(row), 32'h0);
    check("R1 irq at reset", 32'(irq), 32'h0);
    check("R1 keys at reset", 32'(keys), 32'h0);
    repeat (40) @(negedge clk);
    check("R1 rows idle", 32'(row), 32'h0);
  endtask

  task automatic t_single_key();
    int cyc;
    @(negedge clk) pressed[2*NC+3] = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 scan starts on press, row0 low", 32'(row), 32'h1E);
    check("R4 irq low early", 32'(irq), 32'h0);
    wait_irq(cyc);
    check("R4 irq after one full pass", 32'((cyc >= 50) && (cyc <= 75)), 32'h1);
    check("R7 single key bit 13", 32'(keys), 32'(25'h1 << 13));
  endtask

  task automatic t_order();
    logic [NR-1:0] last;
    last = row;
    check("R6 row0 after pass end", 32'(row), 32'h1E);
    for (int k = 1; k <= NR; k++) begin
      int w = 0;
      while (row == last && w < 40) begin
        @(negedge clk);
        w++;
      end
      check("R6 row order", 32'(row), 32'(~(5'b1 << (k % NR)) & 5'h1F));
      check("R6 row width", 32'((w >= 10) && (w <= 13)), 32'h1);
      last = row;
    end
  endtask

  task automatic t_continue_and_stop();
    repeat (130) @(negedge clk);
    check("R3 still scanning", 32'(row != 0), 32'h1);
    check("R4 irq held", 32'(irq), 32'h1);
    pulse_stop();
    check("R5 rows low after stop", 32'(row), 32'h0);
    check("R5 irq low after stop", 32'(irq), 32'h0);
  endtask

  task automatic t_held_key();
    int cyc;
    repeat (150) @(negedge clk);
    check("R10 no restart with key held", 32'(row), 32'h0);
    @(negedge clk) pressed[2*NC+3] = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 scan starts on release", 32'(row), 32'h1E);
    wait_irq(cyc);
    check("R7 release recorded", 32'(keys), 32'h0);
    pulse_stop();
    check("R5 stopped", 32'(row), 32'h0);
  endtask

  task automatic t_idle_stop();
    repeat (10) @(negedge clk);
    pulse_stop();
    repeat (3) @(negedge clk);
    check("R9 idle stop rows", 32'(row), 32'h0);
    check("R9 idle stop irq", 32'(irq), 32'h0);
  endtask

  task automatic t_multi_key();
    int cyc;
    logic [24:0] exp;
    exp = '0;
    exp[0] = 1'b1; exp[24] = 1'b1; exp[1*NC+3] = 1'b1; exp[3*NC+0] = 1'b1;
    @(negedge clk) pressed = exp;
    repeat (5) @(negedge clk);
    check("R2 multi press starts", 32'(row != 0), 32'h1);
    wait_irq(cyc);
    check("R7 multi key vector", 32'(keys), 32'(exp));
  endtask

  task automatic t_stale_stop();
    // Key change after the first pass makes the next stop stale.
    @(negedge clk) pressed[0] = 1'b0;
    repeat (80) @(negedge clk);
    pulse_stop();
    repeat (2) @(negedge clk);
    check("R8 first stop ignored, rows", 32'(row != 0), 32'h1);
    check("R8 first stop ignored, irq", 32'(irq), 32'h1);
    check("R7 change recorded", 32'(keys[0]), 32'h0);
    pulse_stop();
    check("R8 second stop halts", 32'(row), 32'h0);
    check("R8 irq low after second stop", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_key();
    t_order();
    t_continue_and_stop();
    t_held_key();
    t_idle_stop();
    t_multi_key();
    t_stale_stop();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule